// File: doc/BRIEF.md
# Byte/Word ALU with Flag Register

This block is an arithmetic logic unit that works on either 8-bit or 16-bit operands and keeps a 16-bit flag register beside it. A width select picks byte or word operation. Each accepted operation produces a registered result and refreshes six status flags: carry, parity, half-carry, zero, sign and overflow. The operations are add, subtract, increment, decrement, AND, OR, XOR, complement, and single-bit shifts (left, logical right, arithmetic right).

Three control flags share the register: trap, interrupt enable and direction. No operation changes them. Each one is written only through its own set and clear inputs. Bits of the register that carry no flag always read as zero.

The surrounding execution logic presents an operation with `op_valid` for one cycle. The result and the flags become visible on the outputs after the next rising clock edge.

Top module: `alu_flags`

## Requirements
- R1: The flag register keeps CF at bit 0, PF at bit 2, AF at bit 4, ZF at bit 6, SF at bit 7, TF at bit 8, IF at bit 9, DF at bit 10 and OF at bit 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R2: When `op_valid` is high at a rising edge, `result` and the status flags show that operation's outcome from that edge onward. Opcodes are ADD=0, SUB=1, INC=2, DEC=3, AND=4, OR=5, XOR=6, NOT=7, SHL=8, SHR=9, SAR=10. For ADD, CF is the carry out of the top bit of the selected width. For SUB, CF is the borrow.
- R3: For add and increment, AF is the carry out of bit 3. For subtract and decrement, AF is the borrow into bit 4. Every other operation clears AF.
- R4: For the arithmetic operations, OF is set when the two's-complement result falls outside the signed range of the selected width.
- R5: ZF is set when the result of the selected width is zero. SF equals the top bit of that result: bit 7 for byte operations, bit 15 for word operations.
- R6: PF is 1 when bits 7:0 of the result hold an even number of ones. This is the same at both widths.
- R7: AND, OR, XOR and NOT clear CF, OF and AF.
- R8: INC and DEC leave CF unchanged and ignore `opb`.
- R9: SHL moves the old top bit into CF and sets OF to the new top bit XOR CF. SHR moves bit 0 into CF, shifts in 0, and sets OF to the old top bit. SAR moves bit 0 into CF, copies the top bit, and clears OF.
- R10: With `wide`=0, operand bits 15:8 have no effect and result bits 15:8 read 0.
- R11: Bits 0, 1 and 2 of `ctl_set` and `ctl_clr` address TF, IF and DF. A set bit raises its flag at the next edge and a clear bit lowers it. Clear wins when both are given. Operations never change these flags.
- R12: Opcodes 11 to 15 change neither `result` nor any status flag.
- R13: After reset, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Apply the operation at this edge |
| op_code | input | 4 | Operation select |
| wide | input | 1 | 1 = word, 0 = byte |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| ctl_set | input | 3 | Set TF/IF/DF (bit 0/1/2) |
| ctl_clr | input | 3 | Clear TF/IF/DF (bit 0/1/2) |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag register |

## Verification
The assertions are checked on every cycle. They cover the zero undefined bits, ZF, SF and PF agreeing with the registered result, logic operations clearing CF, OF and AF, INC and DEC keeping CF, unknown opcodes holding state, the upper byte in byte mode, and the set and clear behaviour of the control flags. Some values can only be shown by the bench's scenarios: the exact carry, half-carry and overflow values, the shift flag rules, and the fact that upper operand bits are ignored. The bench checks these against its own integer model of each operation at both widths, with both directed and random operands.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_SAR = 4'd10
  } alu_op_e;

  // Flag positions: a neighbouring decoder reads them at these bits.
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 2;
  localparam int FLG_AF = 4;
  localparam int FLG_ZF = 6;
  localparam int FLG_SF = 7;
  localparam int FLG_CTL_LO = 8;  // TF, IF, DF at 8, 9, 10
  localparam int FLG_OF = 11;
  localparam int NUM_CTL = 3;
  localparam int FLAG_W = 16;

  localparam logic [FLAG_W-1:0] FLAG_STATUS_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] FLAG_DEFINED_MASK = 16'h0FD5;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zero;
    logic aux;
    logic par;
    logic cry;
  } stat_t;

  function automatic logic even_ones8(logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flags_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e         op,
  input  logic            wide,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            cry,
  output logic            aux,
  output logic            ovf,
  output logic            keep_cf,
  output logic            known
);
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] narrow(logic [DW-1:0] v, logic w);
    return w ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  function automatic logic top_bit(logic [DW-1:0] v, logic w);
    return w ? v[DW-1] : v[HW-1];
  endfunction

  function automatic logic carry_at(logic [DW:0] s, logic w);
    return w ? s[DW] : s[HW];
  endfunction

  logic [DW-1:0] am, bm, rhs, topmask, nib_x;
  logic [DW:0]   sum_x, dif_x;
  logic [DW-1:0] raw;

  always_comb begin
    am      = narrow(a, wide);
    bm      = narrow(b, wide);
    rhs     = (op == OP_INC || op == OP_DEC) ? DW'(1) : bm;
    sum_x   = {1'b0, am} + {1'b0, rhs};
    dif_x   = {1'b0, am} - {1'b0, rhs};
    topmask = wide ? {1'b1, {(DW-1){1'b0}}}
                   : {{(DW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};
    raw     = '0;
    cry     = 1'b0;
    aux     = 1'b0;
    ovf     = 1'b0;
    keep_cf = 1'b0;
    known   = 1'b1;
    nib_x   = '0;
    case (op)
      OP_ADD, OP_INC: begin
        raw     = sum_x[DW-1:0];
        cry     = carry_at(sum_x, wide);
        nib_x   = am ^ rhs ^ raw;
        aux     = nib_x[4];
        ovf     = (top_bit(am, wide) == top_bit(rhs, wide)) &&
                  (top_bit(raw, wide) != top_bit(am, wide));
        keep_cf = (op == OP_INC);
      end
      OP_SUB, OP_DEC: begin
        raw     = dif_x[DW-1:0];
        cry     = carry_at(dif_x, wide);
        nib_x   = am ^ rhs ^ raw;
        aux     = nib_x[4];
        ovf     = (top_bit(am, wide) != top_bit(rhs, wide)) &&
                  (top_bit(raw, wide) != top_bit(am, wide));
        keep_cf = (op == OP_DEC);
      end
      OP_AND: raw = am & bm;
      OP_OR:  raw = am | bm;
      OP_XOR: raw = am ^ bm;
      OP_NOT: raw = ~am;
      OP_SHL: begin
        raw = am << 1;
        cry = top_bit(am, wide);
        ovf = top_bit(raw, wide) ^ top_bit(am, wide);
      end
      OP_SHR: begin
        raw = am >> 1;
        cry = am[0];
        ovf = top_bit(am, wide);
      end
      OP_SAR: begin
        raw = (am >> 1) | (am & topmask);
        cry = am[0];
      end
      default: known = 1'b0;
    endcase
    res = narrow(raw, wide);
  end

endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_flags_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] res,
  input  logic          wide,
  input  logic          cry,
  input  logic          aux,
  input  logic          ovf,
  output stat_t         st
);
  localparam int HW = DW / 2;

  always_comb begin
    st.cry  = cry;
    st.aux  = aux;
    st.ovf  = ovf;
    st.zero = (res == '0);
    st.sgn  = wide ? res[DW-1] : res[HW-1];
    st.par  = even_ones8(res[7:0]);
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic               keep_cf,
  input  stat_t              st,
  input  logic [NUM_CTL-1:0] ctl_set,
  input  logic [NUM_CTL-1:0] ctl_clr,
  output logic [FLAG_W-1:0]  flags
);
  stat_t              stat_q;
  logic [NUM_CTL-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd) begin
      stat_q.ovf  <= st.ovf;
      stat_q.sgn  <= st.sgn;
      stat_q.zero <= st.zero;
      stat_q.aux  <= st.aux;
      stat_q.par  <= st.par;
      stat_q.cry  <= keep_cf ? stat_q.cry : st.cry;
    end
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[i] <= 1'b0;
      else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
      else if (ctl_set[i]) ctl_q[i] <= 1'b1;
    end
  end

  always_comb begin
    flags = '0;
    flags[FLG_CF] = stat_q.cry;
    flags[FLG_PF] = stat_q.par;
    flags[FLG_AF] = stat_q.aux;
    flags[FLG_ZF] = stat_q.zero;
    flags[FLG_SF] = stat_q.sgn;
    flags[FLG_OF] = stat_q.ovf;
    flags[FLG_CTL_LO +: NUM_CTL] = ctl_q;
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic          wide,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [2:0]    ctl_set,
  input  logic [2:0]    ctl_clr,
  output logic [DW-1:0] result,
  output logic [15:0]   flags
);
  logic [DW-1:0] dp_res;
  logic          dp_cry, dp_aux, dp_ovf, dp_keep_cf, dp_known;
  stat_t         dp_stat;
  logic          op_fire;

  alu_datapath #(.DW(DW)) u_dp (
    .op      (alu_op_e'(op_code)),
    .wide    (wide),
    .a       (opa),
    .b       (opb),
    .res     (dp_res),
    .cry     (dp_cry),
    .aux     (dp_aux),
    .ovf     (dp_ovf),
    .keep_cf (dp_keep_cf),
    .known   (dp_known)
  );

  alu_status #(.DW(DW)) u_st (
    .res  (dp_res),
    .wide (wide),
    .cry  (dp_cry),
    .aux  (dp_aux),
    .ovf  (dp_ovf),
    .st   (dp_stat)
  );

  assign op_fire = op_valid && dp_known;

  alu_flag_reg u_fr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (op_fire),
    .keep_cf (dp_keep_cf),
    .st      (dp_stat),
    .ctl_set (ctl_set),
    .ctl_clr (ctl_clr),
    .flags   (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (op_fire) result <= dp_res;
  end

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_fire,
  input logic [3:0]    op_code,
  input logic          wide,
  input logic [2:0]    ctl_set,
  input logic [2:0]    ctl_clr,
  input logic [DW-1:0] result,
  input logic [15:0]   flags
);
  localparam int HW = DW / 2;

  logic is_logic, is_step;
  assign is_logic = (op_code >= 4'd4) && (op_code <= 4'd7);
  assign is_step  = (op_code == 4'd2) || (op_code == 4'd3);

  assert_undef_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_DEFINED_MASK) == '0);

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> flags[FLG_ZF] == (result == '0));

  assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> flags[FLG_SF] == ($past(wide) ? result[DW-1] : result[HW-1]));

  assert_parity_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> flags[FLG_PF] == ~^result[7:0]);

  assert_logic_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && is_logic) |=> !flags[FLG_CF] && !flags[FLG_OF] && !flags[FLG_AF]);

  assert_step_keep_cf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && is_step) |=> flags[FLG_CF] == $past(flags[FLG_CF]));

  assert_byte_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && !wide) |=> result[DW-1:HW] == '0);

  assert_unknown_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_fire) |=> $stable(result) && $stable(flags & FLAG_STATUS_MASK));

  assert_ctl_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr != 3'b000) |=> (flags[FLG_CTL_LO +: NUM_CTL] & $past(ctl_clr)) == 3'b000);

  assert_ctl_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set != 3'b000) |=>
      (flags[FLG_CTL_LO +: NUM_CTL] & ($past(ctl_set) & ~$past(ctl_clr)))
        == ($past(ctl_set) & ~$past(ctl_clr)));

  assert_ctl_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags[FLG_CTL_LO +: NUM_CTL]));

endmodule

bind alu_flags alu_flags_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_fire  (op_fire),
  .op_code  (op_code),
  .wide     (wide),
  .ctl_set  (ctl_set),
  .ctl_clr  (ctl_clr),
  .result   (result),
  .flags    (flags)
);

// File: tb/sim_alu_flags.sv
module sim_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [2:0]  ctl_set = '0;
  logic [2:0]  ctl_clr = '0;
  logic [15:0] result;
  logic [15:0] flags;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_res = '0;
  logic [15:0] exp_flg = '0;
  logic [2:0]  exp_ctl = '0;

  always #5 clk = ~clk;

  alu_flags u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wide(wide), .opa(opa), .opb(opb), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .result(result), .flags(flags)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Integer model of one operation; returns result and full flag word.
  task automatic model(input int op, input bit w, input int a, input int b,
                       output logic [15:0] r_o, output logic [15:0] f_o);
    int nb, md, half, ua, ub, sa, sb, s, r;
    bit cf, af, of, zf, sf, pf;
    nb = w ? 16 : 8;
    md = 1 << nb;
    half = md / 2;
    ua = a & (md - 1);
    ub = b & (md - 1);
    if (op == 2 || op == 3) ub = 1;
    sa = (ua >= half) ? ua - md : ua;
    sb = (ub >= half) ? ub - md : ub;
    cf = 0; af = 0; of = 0; r = 0;
    case (op)
      0, 2: begin
        r = (ua + ub) & (md - 1);
        cf = (ua + ub) >= md;
        af = ((ua & 15) + (ub & 15)) > 15;
        s = sa + sb;
        of = (s >= half) || (s < -half);
      end
      1, 3: begin
        r = (ua - ub) & (md - 1);
        cf = ua < ub;
        af = (ua & 15) < (ub & 15);
        s = sa - sb;
        of = (s >= half) || (s < -half);
      end
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      7: r = (~ua) & (md - 1);
      8: begin r = (ua * 2) & (md - 1); cf = ua >= half; of = (r >= half) != cf; end
      9: begin r = ua / 2; cf = ua[0]; of = ua >= half; end
      default: begin r = ua / 2 + ((ua >= half) ? half : 0); cf = ua[0]; end
    endcase
    if (op == 2 || op == 3) cf = exp_flg[0];
    zf = (r == 0);
    sf = (r >= half);
    pf = ($countones(r & 255) % 2) == 0;
    r_o = r[15:0];
    f_o = 16'(({13'd0, exp_ctl} << 8) | (int'(of) << 11) | (int'(sf) << 7) |
              (int'(zf) << 6) | (int'(af) << 4) | (int'(pf) << 2) | int'(cf));
  endtask

  task automatic do_op(input string tag, input int op, input bit w,
                       input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r, f;
    if (op <= 10) begin
      model(op, w, a, b, r, f);
      exp_res = r;
      exp_flg = f;
    end
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'(op); wide = w; opa = a; opb = b;
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " result"}, result, exp_res);
    check({tag, " flags"}, flags, exp_flg);
  endtask

  task automatic do_ctl(input string tag, input logic [2:0] s, input logic [2:0] c);
    @(negedge clk);
    ctl_set = s; ctl_clr = c;
    @(negedge clk);
    ctl_set = '0; ctl_clr = '0;
    exp_ctl = (exp_ctl | s) & ~c;
    exp_flg[10:8] = exp_ctl;
    check(tag, flags, exp_flg);
  endtask

  task automatic t_reset;
    check("R13 reset result", result, 16'h0000);
    check("R13 reset flags", flags, 16'h0000);
  endtask

  task automatic t_add_sub;
    do_op("R2 R3 R5 R6 byte add wrap", 0, 0, 16'h00FF, 16'h0001);
    check("R2 literal", flags, 16'h0055);           // CF AF ZF PF
    do_op("R4 byte add ovf", 0, 0, 16'h007F, 16'h0001);
    check("R4 literal", flags, 16'h0890);           // OF SF AF
    do_op("R4 R6 word add ovf", 0, 1, 16'h7FFF, 16'h0001);
    check("R6 literal", flags, 16'h0894);           // OF SF AF PF(low byte 0)
    do_op("R2 R3 byte borrow", 1, 0, 16'h0000, 16'h0001);
    do_op("R4 word sub ovf", 1, 1, 16'h8000, 16'h0001);
    do_op("R2 word carry", 0, 1, 16'hF000, 16'h1000);
  endtask

  task automatic t_step;
    do_op("R8 set carry", 0, 1, 16'hFFFF, 16'h0001);
    do_op("R8 inc keeps CF", 2, 1, 16'h1234, 16'hFFFF);
    check("R8 CF held", {15'd0, flags[0]}, 16'h0001);
    do_op("R8 clear carry", 4, 1, 16'h0F0F, 16'h00FF);
    do_op("R8 dec keeps CF", 3, 0, 16'h0000, 16'h0055);
    check("R8 dec result", result, 16'h00FF);
  endtask

  task automatic t_logic;
    do_op("R9 prime flags", 0, 0, 16'h0080, 16'h0080);
    do_op("R7 and", 4, 1, 16'hF0F0, 16'hFF00);
    do_op("R7 or", 5, 0, 16'h0012, 16'h0081);
    do_op("R7 xor zero", 6, 1, 16'hABCD, 16'hABCD);
    do_op("R7 not", 7, 0, 16'h00F0, 16'h0000);
  endtask

  task automatic t_shift;
    do_op("R9 shl byte", 8, 0, 16'h00C1, 16'h0000);
    do_op("R9 shl word ovf", 8, 1, 16'h4000, 16'h0000);
    do_op("R9 shr byte", 9, 0, 16'h0081, 16'h0000);
    do_op("R9 sar word", 10, 1, 16'h8003, 16'h0000);
    check("R9 sar literal", result, 16'hC001);
    do_op("R9 sar byte", 10, 0, 16'h0080, 16'h0000);
  endtask

  task automatic t_byte;
    do_op("R10 upper ignored", 0, 0, 16'hAB12, 16'hCD34);
    check("R10 literal", result, 16'h0046);
    do_op("R10 not upper zero", 7, 0, 16'hFF00, 16'hFFFF);
    check("R10 not literal", result, 16'h00FF);
  endtask

  task automatic t_ctl;
    do_ctl("R11 set TF", 3'b001, 3'b000);
    do_ctl("R11 set IF DF", 3'b110, 3'b000);
    do_op("R11 op keeps ctl", 0, 1, 16'h0001, 16'h0002);
    do_ctl("R11 clear wins", 3'b010, 3'b010);
    do_ctl("R11 clear TF", 3'b000, 3'b001);
    check("R1 R11 layout", flags & 16'h0700, 16'h0400);
  endtask

  task automatic t_unknown;
    do_op("R12 prime", 1, 1, 16'h1000, 16'h2000);
    for (int k = 11; k < 16; k++) do_op("R12 unused opcode", k, 1, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      do_op("R2 R3 R4 R5 R6 random", i % 11, bit'(i[4]),
            16'($urandom), 16'($urandom));
      check("R1 undefined zero", flags & 16'hF02A, 16'h0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_sub();
    t_step();
    t_logic();
    t_shift();
    t_byte();
    t_ctl();
    t_unknown();
    t_random();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule